// File: doc/BRIEF.md
# Cache Maintenance and Region Control Unit

This unit sits beside a small cache that has separate instruction and data sides. It holds the control state that software programs through a simple register port. It decides, for every fetch or load address, whether the access may be cached and whether the addressed line is currently valid. Tags, data storage and the refill sequencing live elsewhere. This unit owns only one valid bit per line for each side.

Cacheability is set per 32 KB window by a bitmask register. A global enable bit gates every window. Software maintains the caches in two ways. It can clear a whole side by raising that side's clear bit from 0 to 1. It can drop a single line by raising a command bit from 0 to 1 in a write to the invalidate register. Writing a command value again without first writing 0 does nothing. The refill engine reports completed fills on the fill port, which marks the filled line valid.

Top module: `cache_maint_unit`

## Requirements
- R1: After reset, every register reads 0, every lookup reports uncacheable, and no lookup reports a hit.
- R2: Bit n of the region register (reg_sel 0) makes the window from n*0x8000 to n*0x8000+0x7FFF cacheable. Addresses at or above N_REGIONS*0x8000 are never cacheable.
- R3: When bit 0 (enable) of the function register (reg_sel 1) is 0, lookups report uncacheable and no hit. A hit is never reported without cacheable.
- R4: A fill with fill_line L sets valid for line L of the side chosen by fill_is_data (1 = data). A lookup indexes the line with lk_addr bits 11:5 on the side chosen by lk_is_data. lk_cacheable and lk_hit appear one cycle after lk_addr. They reflect the state before that cycle's writes and fills.
- R5: A write to the function register that takes bit 1 from 0 to 1 clears every data line and leaves the instruction lines untouched. Writing bit 1 as 1 while it is already 1 clears nothing.
- R6: A write to the function register that takes bit 2 from 0 to 1 clears every instruction line and leaves the data lines untouched. Writing bit 2 as 1 while it is already 1 clears nothing.
- R7: A write to the invalidate register (reg_sel 2) that takes bit 31 from 0 to 1 clears the data line given by bits 22:16. These are the low seven bits of the field in bits 26:16.
- R8: A write to the invalidate register that takes bit 15 from 0 to 1 clears the instruction line given by bits 6:0. Both commands may act in one write.
- R9: A write that leaves bit 31 or bit 15 at 1 while it was already 1 invalidates nothing.
- R10: A clear or a line invalidate in the same cycle as a fill to an affected line wins, and the line ends invalid.
- R11: Reads return their data on reg_rdata one cycle after reg_rd and hold it until the next read. The region and function registers return the last value written. The invalidate register and reg_sel 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | 0 region, 1 function, 2 invalidate |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| lk_addr | input | 32 | Lookup byte address |
| lk_is_data | input | 1 | Lookup side: 1 data, 0 instruction |
| lk_cacheable | output | 1 | Registered cacheable result |
| lk_hit | output | 1 | Registered hit result |
| fill_en | input | 1 | Fill completed |
| fill_is_data | input | 1 | Fill side: 1 data, 0 instruction |
| fill_line | input | 7 | Line index being filled |

## Verification
The bench builds the unit with its default parameters: 128 lines per side, 32-byte lines and 32 regions of 32 KB. With these values the lookup index is bits 11:5, and the region mask spans a full 32-bit register. Window edges up to 0xFFFFF and the first uncached address 0x100000 can therefore be probed directly. A behavioural model with plain bit arrays is compared with all three outputs on every clock. The bench drives directed sequences for clears, repeated commands and fill collisions, then a random mix.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  typedef enum logic [1:0] {
    SEL_REGION = 2'd0,
    SEL_FUNC   = 2'd1,
    SEL_INVAL  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int FN_ENABLE_BIT = 0;
  localparam int FN_DCLR_BIT   = 1;
  localparam int FN_ICLR_BIT   = 2;
  localparam int INV_D_BIT     = 31;
  localparam int INV_I_BIT     = 15;
  localparam int INV_D_LSB     = 16;
  localparam int INV_I_LSB     = 0;

  typedef struct packed {
    logic clear;
    logic inv;
  } maint_cmd_t;
endpackage

// File: rtl/cmu_regs.sv
module cmu_regs
  import cmu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int N_REGIONS = 32,
  parameter int IDX_W     = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [1:0]           sel,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [N_REGIONS-1:0] region_mask,
  output logic                 enable,
  output maint_cmd_t           d_cmd,
  output maint_cmd_t           i_cmd,
  output logic [IDX_W-1:0]     d_inv_idx,
  output logic [IDX_W-1:0]     i_inv_idx
);
  logic [N_REGIONS-1:0] region_q;
  logic [DATA_W-1:0]    func_q;
  logic                 inv_d_q, inv_i_q;
  logic                 wr_func, wr_inval;

  assign wr_func  = wr && (sel == SEL_FUNC);
  assign wr_inval = wr && (sel == SEL_INVAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      region_q <= '0;
      func_q   <= '0;
      inv_d_q  <= 1'b0;
      inv_i_q  <= 1'b0;
      rdata    <= '0;
    end else begin
      if (wr && (sel == SEL_REGION)) region_q <= wdata[N_REGIONS-1:0];
      if (wr_func) func_q <= wdata;
      if (wr_inval) begin
        inv_d_q <= wdata[INV_D_BIT];
        inv_i_q <= wdata[INV_I_BIT];
      end
      if (rd) begin
        case (sel)
          SEL_REGION: rdata <= DATA_W'(region_q);
          SEL_FUNC:   rdata <= func_q;
          default:    rdata <= '0;
        endcase
      end
    end
  end

  // Commands act only on a 0 -> 1 transition of their bit.
  assign d_cmd.clear = wr_func && wdata[FN_DCLR_BIT] && !func_q[FN_DCLR_BIT];
  assign i_cmd.clear = wr_func && wdata[FN_ICLR_BIT] && !func_q[FN_ICLR_BIT];
  assign d_cmd.inv   = wr_inval && wdata[INV_D_BIT] && !inv_d_q;
  assign i_cmd.inv   = wr_inval && wdata[INV_I_BIT] && !inv_i_q;
  assign d_inv_idx   = wdata[INV_D_LSB +: IDX_W];
  assign i_inv_idx   = wdata[INV_I_LSB +: IDX_W];

  assign region_mask = region_q;
  assign enable      = func_q[FN_ENABLE_BIT];

  // R11: the invalidate register always reads back as zero
  a_r11_inval_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_INVAL) |=> (rdata == '0));

  // R9: an identical back-to-back invalidate write issues no command
  a_r9_no_repeat: assert property (@(posedge clk) disable iff (rst)
    (wr_inval && $past(wr_inval) && (wdata == $past(wdata)))
      |-> (!d_cmd.inv && !i_cmd.inv));
endmodule

// File: rtl/cmu_region_check.sv
module cmu_region_check #(
  parameter int ADDR_W      = 32,
  parameter int REGION_LOG2 = 15,
  parameter int N_REGIONS   = 32
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [N_REGIONS-1:0] region_mask,
  input  logic                 enable,
  output logic                 cacheable
);
  localparam int RI_W = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1;

  logic [ADDR_W-1:0] win;
  logic              in_range;

  always_comb begin
    win       = addr >> REGION_LOG2;
    in_range  = (win < ADDR_W'(N_REGIONS));
    cacheable = enable && in_range && region_mask[RI_W'(win)];
  end
endmodule

// File: rtl/cmu_valid_array.sv
module cmu_valid_array #(
  parameter int N_LINES = 128,
  parameter int IDX_W   = $clog2(N_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inv,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             fill,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid
);
  logic [N_LINES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      valid_q <= '0;
    end else begin
      if (fill) valid_q[fill_idx] <= 1'b1;
      if (inv)  valid_q[inv_idx]  <= 1'b0;  // later assignment wins over a fill
    end
  end

  assign rd_valid = valid_q[rd_idx];

  // R5/R6: a whole-side clear leaves no valid line
  a_r5_clear_all: assert property (@(posedge clk) disable iff (rst)
    clear |=> (valid_q == '0));

  // R7/R8/R10: an invalidated line is invalid next cycle even under a fill
  a_r10_inv_wins: assert property (@(posedge clk) disable iff (rst)
    inv |=> !valid_q[$past(inv_idx)]);

  // R4: an unopposed fill sets the line
  a_r4_fill_sets: assert property (@(posedge clk) disable iff (rst)
    (fill && !clear && !(inv && inv_idx == fill_idx)) |=> valid_q[$past(fill_idx)]);
endmodule

// File: rtl/cache_maint_unit.sv
module cache_maint_unit
  import cmu_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_LOG2   = 5,
  parameter int N_LINES     = 128,
  parameter int REGION_LOG2 = 15,
  parameter int N_REGIONS   = 32,
  localparam int IDX_W      = $clog2(N_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_is_data,
  output logic              lk_cacheable,
  output logic              lk_hit,
  input  logic              fill_en,
  input  logic              fill_is_data,
  input  logic [IDX_W-1:0]  fill_line
);
  logic [N_REGIONS-1:0] region_mask;
  logic                 enable;
  maint_cmd_t           cmd    [2];
  logic [IDX_W-1:0]     inv_idx[2];
  logic                 side_valid[2];
  logic [IDX_W-1:0]     lk_idx;
  logic                 cacheable;

  cmu_regs #(
    .DATA_W(DATA_W), .N_REGIONS(N_REGIONS), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata), .region_mask(region_mask),
    .enable(enable), .d_cmd(cmd[1]), .i_cmd(cmd[0]),
    .d_inv_idx(inv_idx[1]), .i_inv_idx(inv_idx[0])
  );

  cmu_region_check #(
    .ADDR_W(ADDR_W), .REGION_LOG2(REGION_LOG2), .N_REGIONS(N_REGIONS)
  ) u_region (
    .addr(lk_addr), .region_mask(region_mask), .enable(enable),
    .cacheable(cacheable)
  );

  assign lk_idx = IDX_W'(lk_addr >> LINE_LOG2);

  // index 0: instruction side, index 1: data side
  for (genvar g = 0; g < 2; g++) begin : g_side
    logic side_fill;
    assign side_fill = fill_en && (fill_is_data == g[0]);
    cmu_valid_array #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_valid (
      .clk(clk), .rst(rst), .clear(cmd[g].clear), .inv(cmd[g].inv),
      .inv_idx(inv_idx[g]), .fill(side_fill), .fill_idx(fill_line),
      .rd_idx(lk_idx), .rd_valid(side_valid[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_cacheable <= 1'b0;
      lk_hit       <= 1'b0;
    end else begin
      lk_cacheable <= cacheable;
      lk_hit       <= cacheable && side_valid[lk_is_data];
    end
  end

  // R3: no hit without cacheable
  a_r3_hit_needs_cacheable: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_cacheable);

  // R3: disabled unit never reports cacheable
  a_r3_off_uncached: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !lk_cacheable);

  // R2: addresses past the last window are uncached
  a_r2_outside_uncached: assert property (@(posedge clk) disable iff (rst)
    ((lk_addr >> REGION_LOG2) >= ADDR_W'(N_REGIONS)) |=> !lk_cacheable);
endmodule

// File: tb/test_cache_maint_unit.sv
module test_cache_maint_unit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [31:0] lk_addr = 0;
  logic        lk_is_data = 0;
  logic        lk_cacheable, lk_hit;
  logic        fill_en = 0, fill_is_data = 0;
  logic [6:0]  fill_line = 0;

  int    errors = 0, checks = 0;
  string phase = "R1";
  bit    checking = 0;

  always #(PERIOD/2) clk = ~clk;

  cache_maint_unit i_cache_maint_unit (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_is_data(lk_is_data), .lk_cacheable(lk_cacheable), .lk_hit(lk_hit),
    .fill_en(fill_en), .fill_is_data(fill_is_data), .fill_line(fill_line)
  );

  // behavioural reference
  bit          m_region[32];
  bit [31:0]   m_func;
  bit          m_invd, m_invi;
  bit          m_vd[128], m_vi[128];
  bit [31:0]   e_rdata;
  bit          e_c, e_h;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_region[k]) m_region[k] = 0;
      foreach (m_vd[k]) begin m_vd[k] = 0; m_vi[k] = 0; end
      m_func = 0; m_invd = 0; m_invi = 0;
      e_rdata = 0; e_c = 0; e_h = 0;
    end else begin
      int win, li;
      bit clr_d, clr_i, inv_d, inv_i;
      win = int'(lk_addr / 32'h8000);
      li  = int'((lk_addr / 32) % 128);
      e_c = m_func[0] && (lk_addr < 32'h10_0000) && m_region[win % 32];
      e_h = e_c && (lk_is_data ? m_vd[li] : m_vi[li]);
      if (reg_rd) begin
        if (reg_sel == 0) begin
          e_rdata = 0;
          for (int k = 0; k < 32; k++) e_rdata[k] = m_region[k];
        end else if (reg_sel == 1) e_rdata = m_func;
        else e_rdata = 0;
      end
      clr_d = reg_wr && reg_sel == 1 && reg_wdata[1] && !m_func[1];
      clr_i = reg_wr && reg_sel == 1 && reg_wdata[2] && !m_func[2];
      inv_d = reg_wr && reg_sel == 2 && reg_wdata[31] && !m_invd;
      inv_i = reg_wr && reg_sel == 2 && reg_wdata[15] && !m_invi;
      if (fill_en) begin
        if (fill_is_data) m_vd[fill_line] = 1; else m_vi[fill_line] = 1;
      end
      if (inv_d) m_vd[(reg_wdata >> 16) % 128] = 0;
      if (inv_i) m_vi[reg_wdata % 128] = 0;
      if (clr_d) foreach (m_vd[k]) m_vd[k] = 0;
      if (clr_i) foreach (m_vi[k]) m_vi[k] = 0;
      if (reg_wr && reg_sel == 0) for (int k = 0; k < 32; k++) m_region[k] = reg_wdata[k];
      if (reg_wr && reg_sel == 1) m_func = reg_wdata;
      if (reg_wr && reg_sel == 2) begin m_invd = reg_wdata[31]; m_invi = reg_wdata[15]; end
    end
  end

  // per-cycle comparison, 1 time unit after the edge
  always begin
    @(posedge clk);
    #1;
    if (checking) begin
      checks += 3;
      if (lk_cacheable !== e_c) begin
        errors++;
        $display("FAIL %s lk_cacheable actual=%b expected=%b addr=%h", phase, lk_cacheable, e_c, lk_addr);
      end
      if (lk_hit !== e_h) begin
        errors++;
        $display("FAIL %s lk_hit actual=%b expected=%b addr=%h", phase, lk_hit, e_h, lk_addr);
      end
      if (reg_rdata !== e_rdata) begin
        errors++;
        $display("FAIL %s reg_rdata actual=%h expected=%h", phase, reg_rdata, e_rdata);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; fill_en = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_wr = 1; reg_sel = s; reg_wdata = d; tick();
  endtask

  task automatic rd(input logic [1:0] s);
    reg_rd = 1; reg_sel = s; tick();
  endtask

  task automatic look(input logic [31:0] a, input logic d);
    lk_addr = a; lk_is_data = d; tick();
  endtask

  task automatic fill(input logic d, input logic [6:0] l);
    fill_en = 1; fill_is_data = d; fill_line = l; tick();
  endtask

  // explicit check at a port, used for direct requirement probes
  task automatic expect_hit(input string req, input logic [31:0] a, input logic d, input logic exp);
    look(a, d);
    #1;
    checks++;
    if (lk_hit !== exp) begin
      errors++;
      $display("FAIL %s direct hit addr=%h actual=%b expected=%b", req, a, lk_hit, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    checking = 1;
    // R1: reset state
    phase = "R1";
    rd(0); rd(1); rd(2); rd(3);
    look(32'h0, 0); look(32'h0, 1); look(32'h8_0040, 1); tick();

    // R11: readback
    phase = "R11";
    wr(0, 32'h00FF_FF0F); rd(0);
    wr(1, 32'h0000_0001); rd(1);
    wr(2, 32'h0000_0000); rd(2);
    wr(2, 32'h8000_8003); rd(2); rd(3);
    wr(2, 32'h0);

    // R2: window boundaries
    phase = "R2";
    wr(0, 32'h00AA_5501);
    look(32'h0000_7FFF, 0); look(32'h0000_8000, 0); look(32'h000B_FFFF, 1);
    look(32'h000C_0000, 1); look(32'h0010_0000, 0); look(32'hFFFF_FFE0, 1);
    wr(0, 32'h8000_0001);
    look(32'h000F_FFFF, 0); look(32'h0010_0000, 0); look(32'h0000_0000, 1);
    for (int n = 0; n < 32; n++) begin
      wr(0, 32'h1 << n);
      look(32'h8000 * n, n[0]); look(32'h8000 * n + 32'h7FFF, 1);
      look(32'h8000 * ((n + 1) % 32), 0);
    end
    wr(0, 32'hFFFF_FFFF);

    // R4: fills, lookup sees pre-fill state in its own cycle
    phase = "R4";
    lk_addr = 32'h0000_0060; lk_is_data = 1;
    fill(1, 7'd3);
    expect_hit("R4", 32'h0000_0060, 1, 1'b1);
    expect_hit("R4", 32'h0000_0060, 0, 1'b0);
    expect_hit("R4", 32'h0001_0060, 1, 1'b1);
    fill(0, 7'd127);
    expect_hit("R4", 32'h0000_0FE0, 0, 1'b1);
    for (int k = 0; k < 20; k++) fill(k[0], 7'(k * 5));
    for (int k = 0; k < 40; k++) look(32'(k * 32 * 3), k[1]);

    // R3: disable
    phase = "R3";
    wr(1, 32'h0);
    expect_hit("R3", 32'h0000_0060, 1, 1'b0);
    look(32'h0000_0FE0, 0);
    wr(1, 32'h1);
    expect_hit("R3", 32'h0000_0060, 1, 1'b1);

    // R5: data clear
    phase = "R5";
    wr(1, 32'h3);
    expect_hit("R5", 32'h0000_0060, 1, 1'b0);
    expect_hit("R5", 32'h0000_0FE0, 0, 1'b1);
    fill(1, 7'd3);
    wr(1, 32'h3);
    expect_hit("R5", 32'h0000_0060, 1, 1'b1);

    // R6: instruction clear
    phase = "R6";
    wr(1, 32'h5);
    expect_hit("R6", 32'h0000_0FE0, 0, 1'b0);
    expect_hit("R6", 32'h0000_0060, 1, 1'b1);
    fill(0, 7'd9);
    wr(1, 32'h7);
    expect_hit("R6", 32'h0000_0120, 0, 1'b1);
    wr(1, 32'h1);

    // R7: data line invalidate (line in bits 22:16)
    phase = "R7";
    fill(1, 7'd40); fill(1, 7'd41);
    wr(2, 32'h0); wr(2, 32'h8000_0000 | (32'd40 << 16));
    expect_hit("R7", 32'd40 * 32, 1, 1'b0);
    expect_hit("R7", 32'd41 * 32, 1, 1'b1);

    // R8: instruction line invalidate, and both in one write
    phase = "R8";
    fill(0, 7'd70); fill(0, 7'd71); fill(1, 7'd71);
    wr(2, 32'h0); wr(2, 32'h0000_8000 | 32'd70);
    expect_hit("R8", 32'd70 * 32, 0, 1'b0);
    expect_hit("R8", 32'd71 * 32, 0, 1'b1);
    wr(2, 32'h0); wr(2, 32'h8000_8000 | (32'd71 << 16) | 32'd71);
    expect_hit("R8", 32'd71 * 32, 0, 1'b0);
    expect_hit("R8", 32'd71 * 32, 1, 1'b0);

    // R9: repeated value without the zero write does nothing
    phase = "R9";
    fill(0, 7'd71); fill(1, 7'd71);
    wr(2, 32'h8000_8000 | (32'd71 << 16) | 32'd71);
    expect_hit("R9", 32'd71 * 32, 0, 1'b1);
    expect_hit("R9", 32'd71 * 32, 1, 1'b1);

    // R10: command beats same-cycle fill
    phase = "R10";
    wr(2, 32'h0);
    fill_en = 1; fill_is_data = 1; fill_line = 7'd12;
    wr(2, 32'h8000_0000 | (32'd12 << 16));
    expect_hit("R10", 32'd12 * 32, 1, 1'b0);
    wr(1, 32'h1);
    fill_en = 1; fill_is_data = 0; fill_line = 7'd13;
    wr(1, 32'h5);
    expect_hit("R10", 32'd13 * 32, 0, 1'b0);

    // random mix, reference compared every cycle
    phase = "R4";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 9);
      lk_addr = $urandom_range(0, 32'h11_0000); lk_is_data = $urandom_range(0, 1);
      if (r < 3) begin fill_en = 1; fill_is_data = $urandom_range(0, 1); fill_line = 7'($urandom); end
      if (r == 4) begin reg_wr = 1; reg_sel = 2; reg_wdata = $urandom & 32'h80FF_80FF; end
      if (r == 5) begin reg_wr = 1; reg_sel = 1; reg_wdata = $urandom_range(0, 7); end
      if (r == 6) begin reg_wr = 1; reg_sel = 0; reg_wdata = $urandom; end
      if (r == 7) begin reg_rd = 1; reg_sel = 2'($urandom); end
      tick();
    end

    tick(); tick();
    checking = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule